// File: doc/BRIEF.md
# Instruction-Complete Debug Event Unit

This unit sits next to the retirement stage of a simple in-order processor and produces the debug event used for single-stepping. Each cycle it sees a retire strobe with the retiring instruction's address, its length and two flags. One flag says the instruction raised a non-debug exception. The other says it is a system call. When stepping is enabled and a qualifying instruction retires, the unit sets a sticky status flag. It then delivers the event in one of two ways. In internal-debug mode it raises a debug interrupt and saves the address of the next instruction. In external-debug mode it raises a halt request to an attached debugger.

Software or the debugger reaches the unit through a small register write port. It selects either the control register (step enable, debug-exception enable) or the status register (write-one-to-clear). All control and status state is visible on output ports.

The halt request stays high until the debugger pulses resume. After a resume, one more instruction retires and the unit halts again. Every output is a register, so each result appears on the clock edge that samples its cause.

Top module: `step_event_unit`

## Requirements
- R1: After reset, step enable, debug-exception enable, the status flag, the saved return address, the interrupt output and the halt output are all 0.
- R2: A retire while step enable is 1, with no exception flagged, sets the status flag one cycle later. With step enable 0, a retire changes nothing.
- R3: The status flag is not set when internal-debug mode is 1, debug-exception enable is 0 and external-debug mode is 0, all at once. If external-debug mode is 1, the flag is set as usual.
- R4: A retire flagged with a non-debug exception, and not marked as a system call, produces no event: no status, no interrupt, no halt.
- R5: A retire marked as a system call produces the event even when its exception flag is 1.
- R6: A debug interrupt is taken when an event occurs with internal-debug mode 1, external-debug mode 0 and debug-exception enable 1. The interrupt output is then high for exactly one cycle. In that cycle the saved return address equals (address + length) with its ALIGN_LSB low bits forced to 0. Debug-exception enable reads 0 from that cycle on.
- R7: An event with external-debug mode 1 raises the halt output one cycle later, with no interrupt. Halt stays high until a cycle in which resume is 1.
- R8: Retires while halt is high, including a retire in the same cycle as resume, produce no event. The first retire after halt drops raises halt again.
- R9: A status write (select = 1) with data bit 0 set clears the status flag, and with bit 0 clear it leaves the flag unchanged. If a clear and a new event arrive in the same cycle, the flag ends up set.
- R10: A control write (select = 0) loads step enable from data bit 0 and debug-exception enable from data bit 1. If the same cycle also takes a debug interrupt, debug-exception enable ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | AW | Address of the retiring instruction |
| ret_len | input | LEN_W | Length of the retiring instruction in bytes |
| ret_exc | input | 1 | Retiring instruction raised a non-debug exception |
| ret_is_sys | input | 1 | Retiring instruction is a system call |
| mode_int | input | 1 | Internal-debug mode |
| mode_ext | input | 1 | External-debug mode |
| resume | input | 1 | Debugger releases the halt |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control register, 1 = status register |
| cfg_wdata | input | 2 | Write data (control: bit0 step, bit1 debug-exception enable; status: bit0 clear) |
| step_en | output | 1 | Step enable bit |
| dexc_en | output | 1 | Debug-exception enable bit |
| step_status | output | 1 | Sticky instruction-complete status flag |
| dbg_irq | output | 1 | Debug interrupt request, one-cycle pulse |
| halt_req | output | 1 | Halt request to an external debugger, level |
| save_ra | output | AW | Saved return address |

## Verification
Every result is due one clock edge after the cycle that presents its cause: status, enables, interrupt, halt and saved address all update on that edge. The driver applies one stimulus per cycle at the falling edge. For each stimulus it pushes the outputs expected after the next rising edge into a queue, computed from these requirements. A monitor runs one nanosecond after each rising edge and pops exactly one entry per driven cycle, so every comparison lands in the cycle its result is due.

// File: rtl/step_event_pkg.sv
package step_event_pkg;

   localparam int CFG_W        = 2;
   localparam int CTRL_STEP_B  = 0;
   localparam int CTRL_DEXC_B  = 1;
   localparam int STAT_CLR_B   = 0;

   localparam logic SEL_CTRL   = 1'b0;
   localparam logic SEL_STAT   = 1'b1;

   typedef struct packed {
      logic dexc_en;
      logic step_en;
   } step_ctrl_t;

endpackage

// File: rtl/step_qualify.sv
module step_qualify (
   input  logic clk,
   input  logic rst_n,
   input  logic ret_valid,
   input  logic ret_exc,
   input  logic ret_is_sys,
   input  logic mode_int,
   input  logic mode_ext,
   input  logic step_en,
   input  logic dexc_en,
   input  logic halted,
   output logic evt_record,
   output logic irq_take,
   output logic halt_take
);

   logic completes;
   logic hit;
   logic quiet_mode;

   // a system call still completes before its own trap is taken
   assign completes  = !ret_exc || ret_is_sys;
   assign hit        = ret_valid && step_en && completes && !halted;
   assign quiet_mode = mode_int && !dexc_en && !mode_ext;

   assign evt_record = hit && !quiet_mode;
   assign irq_take   = hit && mode_int && !mode_ext && dexc_en;
   assign halt_take  = hit && mode_ext;

   // R3: the quiet mode combination never records status
   a_r3_quiet_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_int && !dexc_en && !mode_ext) |-> !evt_record);

   // R4: faulting instructions raise nothing
   a_r4_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_exc && !ret_is_sys) |-> !(evt_record || irq_take || halt_take));

   // R8: nothing happens while halted
   a_r8_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !(evt_record || irq_take || halt_take));

endmodule

// File: rtl/step_ctrl_regs.sv
module step_ctrl_regs
   import step_event_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             evt_record,
   input  logic             irq_take,
   output logic             step_en_o,
   output logic             dexc_en_o,
   output logic             status_o
);

   step_ctrl_t ctrl_q;
   logic       status_q;
   logic       ctrl_wr;
   logic       stat_clr;

   assign ctrl_wr  = cfg_we && (cfg_sel == SEL_CTRL);
   assign stat_clr = cfg_we && (cfg_sel == SEL_STAT) && cfg_wdata[STAT_CLR_B];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (ctrl_wr) begin
            ctrl_q.step_en <= cfg_wdata[CTRL_STEP_B];
         end
         if (irq_take) begin
            ctrl_q.dexc_en <= 1'b0;
         end else if (ctrl_wr) begin
            ctrl_q.dexc_en <= cfg_wdata[CTRL_DEXC_B];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= 1'b0;
      end else if (evt_record) begin
         status_q <= 1'b1;
      end else if (stat_clr) begin
         status_q <= 1'b0;
      end
   end

   assign step_en_o = ctrl_q.step_en;
   assign dexc_en_o = ctrl_q.dexc_en;
   assign status_o  = status_q;

   // R9: only a clearing status write can drop the flag
   a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !(cfg_we && cfg_sel && cfg_wdata[0])) |=> status_q);

   // R10: a taken interrupt always leaves the exception enable low
   a_r10_irq_kills_dexc: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> !dexc_en_o);

endmodule

// File: rtl/step_delivery.sv
module step_delivery #(
   parameter int AW        = 32,
   parameter int LEN_W     = 4,
   parameter int ALIGN_LSB = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_take,
   input  logic             halt_take,
   input  logic             resume,
   input  logic [AW-1:0]    ret_pc,
   input  logic [LEN_W-1:0] ret_len,
   output logic             dbg_irq_o,
   output logic             halt_o,
   output logic [AW-1:0]    save_ra_o
);

   localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << ALIGN_LSB) - AW'(1));

   logic [AW-1:0] next_pc;
   logic [AW-1:0] ra_next;
   logic          irq_q;
   logic          halt_q;
   logic [AW-1:0] ra_q;

   assign next_pc = ret_pc + AW'(ret_len);

   generate
      if (ALIGN_LSB > 0) begin : g_align
         assign ra_next = next_pc & ALIGN_MASK;
      end else begin : g_noalign
         assign ra_next = next_pc;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         ra_q  <= '0;
      end else begin
         irq_q <= irq_take;
         if (irq_take) begin
            ra_q <= ra_next;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
      end else if (halt_take) begin
         halt_q <= 1'b1;
      end else if (resume) begin
         halt_q <= 1'b0;
      end
   end

   assign dbg_irq_o = irq_q;
   assign halt_o    = halt_q;
   assign save_ra_o = ra_q;

   // R6: the interrupt is a single-cycle pulse
   a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_irq_o |=> !dbg_irq_o);

   // R6: the saved address moves only when an interrupt is taken
   a_r6_ra_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_take |=> $stable(save_ra_o));

   // R7: halt is held until resume
   a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_o && !resume) |=> halt_o);

endmodule

// File: rtl/step_event_unit.sv
module step_event_unit
   import step_event_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LEN_W     = 4,
   parameter int ALIGN_LSB = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ret_valid,
   input  logic [AW-1:0]    ret_pc,
   input  logic [LEN_W-1:0] ret_len,
   input  logic             ret_exc,
   input  logic             ret_is_sys,
   input  logic             mode_int,
   input  logic             mode_ext,
   input  logic             resume,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic             step_en,
   output logic             dexc_en,
   output logic             step_status,
   output logic             dbg_irq,
   output logic             halt_req,
   output logic [AW-1:0]    save_ra
);

   generate
      if (AW < 4) begin : g_bad_aw
         $error("step_event_unit: AW must be at least 4");
      end
      if (LEN_W < 1 || LEN_W > AW) begin : g_bad_len
         $error("step_event_unit: LEN_W must lie in 1..AW");
      end
      if (ALIGN_LSB < 0 || ALIGN_LSB >= AW) begin : g_bad_align
         $error("step_event_unit: ALIGN_LSB must lie in 0..AW-1");
      end
   endgenerate

   logic evt_record;
   logic irq_take;
   logic halt_take;

   step_qualify u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .ret_valid  (ret_valid),
      .ret_exc    (ret_exc),
      .ret_is_sys (ret_is_sys),
      .mode_int   (mode_int),
      .mode_ext   (mode_ext),
      .step_en    (step_en),
      .dexc_en    (dexc_en),
      .halted     (halt_req),
      .evt_record (evt_record),
      .irq_take   (irq_take),
      .halt_take  (halt_take)
   );

   step_ctrl_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .evt_record (evt_record),
      .irq_take   (irq_take),
      .step_en_o  (step_en),
      .dexc_en_o  (dexc_en),
      .status_o   (step_status)
   );

   step_delivery #(
      .AW        (AW),
      .LEN_W     (LEN_W),
      .ALIGN_LSB (ALIGN_LSB)
   ) u_dlv (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_take  (irq_take),
      .halt_take (halt_take),
      .resume    (resume),
      .ret_pc    (ret_pc),
      .ret_len   (ret_len),
      .dbg_irq_o (dbg_irq),
      .halt_o    (halt_req),
      .save_ra_o (save_ra)
   );

   // R2: status rises only after a retire
   a_r2_status_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_status && !ret_valid) |=> !step_status);

endmodule

// File: tb/step_event_unit_test.sv
`timescale 1ns/1ps
module step_event_unit_test;

   localparam int AW = 32;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ret_valid = 1'b0;
   logic [AW-1:0] ret_pc = '0;
   logic [LW-1:0] ret_len = '0;
   logic          ret_exc = 1'b0;
   logic          ret_is_sys = 1'b0;
   logic          mode_int = 1'b0;
   logic          mode_ext = 1'b0;
   logic          resume = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_sel = 1'b0;
   logic [1:0]    cfg_wdata = '0;
   logic          step_en, dexc_en, step_status, dbg_irq, halt_req;
   logic [AW-1:0] save_ra;

   always #2.5 clk = ~clk;

   step_event_unit uut (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
      .ret_len(ret_len), .ret_exc(ret_exc), .ret_is_sys(ret_is_sys),
      .mode_int(mode_int), .mode_ext(mode_ext), .resume(resume),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .step_en(step_en), .dexc_en(dexc_en), .step_status(step_status),
      .dbg_irq(dbg_irq), .halt_req(halt_req), .save_ra(save_ra)
   );

   typedef struct {
      logic          st;
      logic          se;
      logic          de;
      logic          irq;
      logic          hlt;
      logic [AW-1:0] ra;
      string         tag;
   } exp_t;

   exp_t q[$];
   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 0;

   // bench-side state model built from the requirements
   logic          m_st = 0, m_se = 0, m_de = 0, m_hlt = 0;
   logic [AW-1:0] m_ra = '0;

   task automatic drive(input logic rv, input logic [AW-1:0] pc,
                        input logic [LW-1:0] len, input logic exc,
                        input logic sc, input logic mi, input logic me,
                        input logic res, input logic we, input logic sel,
                        input logic [1:0] wd, input string tag);
      logic hit, quiet, rec, itk, htk, clr;
      exp_t e;
      @(negedge clk);
      ret_valid = rv; ret_pc = pc; ret_len = len; ret_exc = exc;
      ret_is_sys = sc; mode_int = mi; mode_ext = me; resume = res;
      cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
      hit   = rv && m_se && (!exc || sc) && !m_hlt;
      quiet = mi && !m_de && !me;
      rec   = hit && !quiet;
      itk   = hit && mi && !me && m_de;
      htk   = hit && me;
      clr   = we && sel && wd[0];
      if (rec) m_st = 1'b1; else if (clr) m_st = 1'b0;
      if (itk) begin
         m_de = 1'b0;
         m_ra = (pc + AW'(len)) & ~AW'(3);
      end else if (we && !sel) begin
         m_de = wd[1];
      end
      if (we && !sel) m_se = wd[0];
      if (htk) m_hlt = 1'b1; else if (res) m_hlt = 1'b0;
      e.st = m_st; e.se = m_se; e.de = m_de; e.irq = itk;
      e.hlt = m_hlt; e.ra = m_ra; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(input string tag);
      drive(0, '0, '0, 0, 0, mode_int, mode_ext, 0, 0, 0, 2'b00, tag);
   endtask

   // monitor: one entry per driven cycle, sampled after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (step_status !== e.st || step_en !== e.se || dexc_en !== e.de ||
                dbg_irq !== e.irq || halt_req !== e.hlt || save_ra !== e.ra) begin
               n_fail++;
               $display("FAIL %s: got st=%b se=%b de=%b irq=%b hlt=%b ra=%h, want st=%b se=%b de=%b irq=%b hlt=%b ra=%h",
                        e.tag, step_status, step_en, dexc_en, dbg_irq, halt_req, save_ra,
                        e.st, e.se, e.de, e.irq, e.hlt, e.ra);
            end
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_run++;
      if (step_en !== 0 || dexc_en !== 0 || step_status !== 0 || dbg_irq !== 0 ||
          halt_req !== 0 || save_ra !== '0) begin
         n_fail++;
         $display("FAIL R1 reset: se=%b de=%b st=%b irq=%b hlt=%b ra=%h, want all 0",
                  step_en, dexc_en, step_status, dbg_irq, halt_req, save_ra);
      end
      rst_n = 1'b1;

      drive(1, 32'h100, 4, 0, 0, 0, 0, 0, 0, 0, 2'b00, "R2 stepping off");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 2'b01, "R10 ctrl write step");
      drive(1, 32'h104, 4, 0, 0, 0, 0, 0, 0, 0, 2'b00, "R2 retire sets status");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 2'b10, "R9 write without clear bit");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 2'b01, "R9 w1c clear");
      drive(1, 32'h108, 4, 0, 0, 1, 0, 0, 0, 0, 2'b00, "R3 quiet mode");
      drive(1, 32'h10C, 4, 0, 0, 1, 1, 0, 0, 0, 2'b00, "R3 R7 ext on halts");
      idle("R7 halt held");
      drive(0, 0, 0, 0, 0, 1, 1, 0, 1, 1, 2'b01, "R9 clear while halted");
      drive(1, 32'h110, 4, 0, 0, 1, 1, 0, 0, 0, 2'b00, "R8 retire while halted");
      drive(1, 32'h110, 4, 0, 0, 1, 1, 1, 0, 0, 2'b00, "R8 retire with resume");
      drive(1, 32'h110, 4, 0, 0, 1, 1, 0, 0, 0, 2'b00, "R8 next retire halts");
      drive(0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 2'b01, "R7 resume and clear");
      drive(1, 32'h200, 4, 1, 0, 0, 0, 0, 0, 0, 2'b00, "R4 faulting retire");
      drive(1, 32'h204, 4, 1, 1, 0, 0, 0, 0, 0, 2'b00, "R5 syscall event");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 2'b11, "R10 ctrl write both");
      drive(1, 32'h1002, 4, 0, 0, 1, 0, 0, 0, 0, 2'b00, "R6 interrupt taken");
      idle("R6 interrupt one cycle");
      drive(1, 32'h1010, 2, 0, 0, 1, 0, 0, 0, 0, 2'b00, "R3 quiet after interrupt");
      drive(0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 2'b11, "R10 re-enable exceptions");
      drive(1, 32'h2000, 8, 0, 1, 1, 0, 0, 1, 0, 2'b11, "R10 irq beats ctrl write");
      idle("R6 ra kept");
      drive(1, 32'h2100, 4, 0, 0, 0, 0, 0, 1, 1, 2'b01, "R9 event beats clear");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 2'b10, "R10 step off");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 2'b01, "R9 clear");
      drive(1, 32'h2200, 4, 0, 0, 0, 1, 0, 0, 0, 2'b00, "R2 off no halt");
      for (int i = 0; i < 6; i++) begin
         drive(i[0], 32'h3000 + 32'(i * 4), 4, i[1], 0, 0, 0, 0,
               (i == 0), 0, 2'b01, "R2 R4 mixed");
      end
      idle("R2 drain");
      repeat (2) @(posedge clk);
      #2;
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule